// File: doc/BRIEF.md
# Bus Address/Data Match Comparator Bank

This block is a set of four bus-watch units for on-chip debug. Each unit looks at one of two processor buses: the primary CPU bus or the coprocessor bus. A unit reports a hit when a valid bus cycle carries the address it holds. The hit can also depend on the transfer direction and, depending on the unit, on the data value or the access size. The four hit pulses go to a trigger sequencer. That sequencer decides what a hit means, so this block does no tracing and raises no breakpoints.

The units are not all the same. Units 0 and 2 compare the address and a 16-bit data value, and each has a per-bit mask. Units 1 and 3 compare the address only, and can be limited to byte or word transfers.

The units work in pairs: unit 0 with unit 1, and unit 2 with unit 3. A pair can switch from two exact-address compares to a single address-range compare. The lower unit's address is the minimum and the upper unit's address is the maximum. The range result appears on the lower unit's output.

Top module: `bus_match_bank`

## Requirements
- R1: After reset `match_o` is all zero, and it stays zero until a qualifying bus cycle occurs.
- R2: Each bit of `match_o` is registered. It is high for exactly the one clock after an edge at which that unit's selected bus had its valid strobe high and every condition below held. The selected bus is given by `cfg_bus_i[k]`: 0 selects the primary bus and 1 selects the coprocessor bus. Activity on the other bus never causes a hit.
- R3: In exact mode, a unit hits only when the bus address equals its own address word exactly. Unit k's address word is `cfg_addr_i[k*ADDR_W +: ADDR_W]`.
- R4: Units 0 and 2 also require the bus data to equal their data word on every bit whose mask bit is 1. Bits whose mask bit is 0 are ignored. For pair p, the data word is slice p of `cfg_data_i` and the mask is slice p of `cfg_mask_i`.
- R5: Units 1 and 3 use a size filter. When `cfg_size_en_i[p]` is 1, the unit hits only if the bus size bit equals `cfg_size_word_i[p]` (1 = word, 0 = byte). When the filter is off, both sizes hit.
- R6: When `cfg_dir_en_i[k]` is 1, unit k hits only if the bus read/write bit equals `cfg_dir_rd_i[k]` (1 = read). When it is 0, both directions hit.
- R7: A unit whose `cfg_en_i[k]` is 0 never sets its output bit.
- R8: Pair p uses the 2-bit mode field `cfg_range_i[2p+1:2p]`. Mode 01 is inside range: the lower unit's output hits when min ≤ address ≤ max. In range modes the lower unit's enable, bus select and direction filter still apply, and its data compare is ignored.
- R9: Mode 10 is outside range: the lower unit's output hits when address < min or address > max, under the same qualifiers as R8.
- R10: In modes 01 and 10 the upper unit's output of the pair stays low. Modes 00 and 11 both give two independent exact compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus0_valid_i | input | 1 | Primary bus cycle strobe |
| bus0_addr_i | input | ADDR_W | Primary bus address |
| bus0_data_i | input | DATA_W | Primary bus data |
| bus0_rnw_i | input | 1 | Primary bus direction, 1 = read |
| bus0_word_i | input | 1 | Primary bus size, 1 = word |
| bus1_valid_i | input | 1 | Coprocessor bus cycle strobe |
| bus1_addr_i | input | ADDR_W | Coprocessor bus address |
| bus1_data_i | input | DATA_W | Coprocessor bus data |
| bus1_rnw_i | input | 1 | Coprocessor bus direction, 1 = read |
| bus1_word_i | input | 1 | Coprocessor bus size, 1 = word |
| cfg_en_i | input | 4 | Per-unit enable |
| cfg_bus_i | input | 4 | Per-unit bus select |
| cfg_dir_en_i | input | 4 | Per-unit direction filter enable |
| cfg_dir_rd_i | input | 4 | Per-unit direction wanted, 1 = read |
| cfg_addr_i | input | 4*ADDR_W | Per-unit address words, unit k in slice k |
| cfg_data_i | input | 2*DATA_W | Data words for units 0 and 2 |
| cfg_mask_i | input | 2*DATA_W | Data masks for units 0 and 2, 1 = compared |
| cfg_size_en_i | input | 2 | Size filter enable for units 1 and 3 |
| cfg_size_word_i | input | 2 | Size wanted for units 1 and 3, 1 = word |
| cfg_range_i | input | 4 | Pair modes, 2 bits per pair |
| match_o | output | 4 | Registered hit pulse per unit |

## Verification
The boundaries of the range modes are the hardest part to reach. A random address almost never lands exactly on the minimum, the maximum, or one step past either.

Directed cases place the bus address on each boundary and just outside it, in both inside and outside mode. One of these addresses also equals the upper unit's exact value, which shows that the upper output stays low in range mode.

The random phase draws both bus addresses and all four unit addresses from a small window of values. Equal and adjacent addresses are therefore common, and the random data, masks, sizes, directions and modes are checked against a reference function in the bench.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
    typedef enum logic [1:0] {
        RNG_OFF = 2'b00,
        RNG_IN  = 2'b01,
        RNG_OUT = 2'b10,
        RNG_ALT = 2'b11
    } rng_mode_e;

    typedef struct packed {
        logic en;
        logic bus;
        logic dir_en;
        logic dir_rd;
    } unit_qual_t;

    localparam int unsigned NUM_UNITS = 4;
    localparam int unsigned NUM_PAIRS = NUM_UNITS / 2;
endpackage

// File: rtl/bmb_bus_sel.sv
module bmb_bus_sel #(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16
) (
    input  logic              sel_i,
    input  logic              b0_valid_i,
    input  logic [ADDR_W-1:0] b0_addr_i,
    input  logic [DATA_W-1:0] b0_data_i,
    input  logic              b0_rnw_i,
    input  logic              b0_word_i,
    input  logic              b1_valid_i,
    input  logic [ADDR_W-1:0] b1_addr_i,
    input  logic [DATA_W-1:0] b1_data_i,
    input  logic              b1_rnw_i,
    input  logic              b1_word_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              rnw_o,
    output logic              word_o
);
    always_comb begin
        if (sel_i) begin
            valid_o = b1_valid_i;
            addr_o  = b1_addr_i;
            data_o  = b1_data_i;
            rnw_o   = b1_rnw_i;
            word_o  = b1_word_i;
        end else begin
            valid_o = b0_valid_i;
            addr_o  = b0_addr_i;
            data_o  = b0_data_i;
            rnw_o   = b0_rnw_i;
            word_o  = b0_word_i;
        end
    end
endmodule

// File: rtl/bmb_unit.sv
module bmb_unit
    import bmb_pkg::*;
#(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16
) (
    input  unit_qual_t        qual_cfg_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_data_i,
    input  logic [DATA_W-1:0] cfg_mask_i,
    input  logic              size_en_i,
    input  logic              size_word_i,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rnw_i,
    input  logic              word_i,
    output logic              qual_o,
    output logic              hit_o
);
    logic dir_ok;
    logic size_ok;
    logic data_ok;
    logic addr_eq;

    always_comb begin
        dir_ok  = !qual_cfg_i.dir_en || (rnw_i == qual_cfg_i.dir_rd);
        size_ok = !size_en_i || (word_i == size_word_i);
        data_ok = ((data_i ^ cfg_data_i) & cfg_mask_i) == '0;
        addr_eq = (addr_i == cfg_addr_i);
        qual_o  = qual_cfg_i.en && valid_i && dir_ok && size_ok;
        hit_o   = qual_o && addr_eq && data_ok;
    end
endmodule

// File: rtl/bmb_pair.sv
module bmb_pair
    import bmb_pkg::*;
#(
    parameter int unsigned ADDR_W = 23
) (
    input  rng_mode_e         mode_i,
    input  logic              lo_qual_i,
    input  logic              lo_hit_i,
    input  logic              hi_hit_i,
    input  logic [ADDR_W-1:0] lo_bus_addr_i,
    input  logic [ADDR_W-1:0] min_addr_i,
    input  logic [ADDR_W-1:0] max_addr_i,
    output logic [1:0]        match_o
);
    logic above_min;
    logic below_max;

    always_comb begin
        above_min = lo_bus_addr_i >= min_addr_i;
        below_max = lo_bus_addr_i <= max_addr_i;
        unique case (mode_i)
            RNG_IN:  match_o = {1'b0, lo_qual_i && above_min && below_max};
            RNG_OUT: match_o = {1'b0, lo_qual_i && (!above_min || !below_max)};
            default: match_o = {hi_hit_i, lo_hit_i};
        endcase
    end
endmodule

// File: rtl/bus_match_bank.sv
module bus_match_bank
    import bmb_pkg::*;
#(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            bus0_valid_i,
    input  logic [ADDR_W-1:0]               bus0_addr_i,
    input  logic [DATA_W-1:0]               bus0_data_i,
    input  logic                            bus0_rnw_i,
    input  logic                            bus0_word_i,
    input  logic                            bus1_valid_i,
    input  logic [ADDR_W-1:0]               bus1_addr_i,
    input  logic [DATA_W-1:0]               bus1_data_i,
    input  logic                            bus1_rnw_i,
    input  logic                            bus1_word_i,
    input  logic [NUM_UNITS-1:0]            cfg_en_i,
    input  logic [NUM_UNITS-1:0]            cfg_bus_i,
    input  logic [NUM_UNITS-1:0]            cfg_dir_en_i,
    input  logic [NUM_UNITS-1:0]            cfg_dir_rd_i,
    input  logic [NUM_UNITS*ADDR_W-1:0]     cfg_addr_i,
    input  logic [NUM_PAIRS*DATA_W-1:0]     cfg_data_i,
    input  logic [NUM_PAIRS*DATA_W-1:0]     cfg_mask_i,
    input  logic [NUM_PAIRS-1:0]            cfg_size_en_i,
    input  logic [NUM_PAIRS-1:0]            cfg_size_word_i,
    input  logic [2*NUM_PAIRS-1:0]          cfg_range_i,
    output logic [NUM_UNITS-1:0]            match_o
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] match;
    } bank_state_t;

    bank_state_t state_d, state_q;

    logic [NUM_UNITS-1:0]  u_qual;
    logic [NUM_UNITS-1:0]  u_hit;
    logic [ADDR_W-1:0]     u_bus_addr [NUM_UNITS];
    logic [NUM_UNITS-1:0]  pair_match;

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
        localparam int unsigned PAIR   = k / 2;
        localparam bit          IS_LOW = (k % 2) == 0;

        logic              s_valid;
        logic [DATA_W-1:0] s_data;
        logic              s_rnw;
        logic              s_word;
        logic [DATA_W-1:0] c_data;
        logic [DATA_W-1:0] c_mask;
        logic              c_size_en;
        logic              c_size_word;
        unit_qual_t        q_cfg;

        assign q_cfg = '{en: cfg_en_i[k], bus: cfg_bus_i[k],
                         dir_en: cfg_dir_en_i[k], dir_rd: cfg_dir_rd_i[k]};

        if (IS_LOW) begin : g_data_unit
            assign c_data      = cfg_data_i[PAIR*DATA_W +: DATA_W];
            assign c_mask      = cfg_mask_i[PAIR*DATA_W +: DATA_W];
            assign c_size_en   = 1'b0;
            assign c_size_word = 1'b0;
        end else begin : g_size_unit
            assign c_data      = '0;
            assign c_mask      = '0;
            assign c_size_en   = cfg_size_en_i[PAIR];
            assign c_size_word = cfg_size_word_i[PAIR];
        end

        bmb_bus_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
            .sel_i      (cfg_bus_i[k]),
            .b0_valid_i (bus0_valid_i),
            .b0_addr_i  (bus0_addr_i),
            .b0_data_i  (bus0_data_i),
            .b0_rnw_i   (bus0_rnw_i),
            .b0_word_i  (bus0_word_i),
            .b1_valid_i (bus1_valid_i),
            .b1_addr_i  (bus1_addr_i),
            .b1_data_i  (bus1_data_i),
            .b1_rnw_i   (bus1_rnw_i),
            .b1_word_i  (bus1_word_i),
            .valid_o    (s_valid),
            .addr_o     (u_bus_addr[k]),
            .data_o     (s_data),
            .rnw_o      (s_rnw),
            .word_o     (s_word)
        );

        bmb_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
            .qual_cfg_i  (q_cfg),
            .cfg_addr_i  (cfg_addr_i[k*ADDR_W +: ADDR_W]),
            .cfg_data_i  (c_data),
            .cfg_mask_i  (c_mask),
            .size_en_i   (c_size_en),
            .size_word_i (c_size_word),
            .valid_i     (s_valid),
            .addr_i      (u_bus_addr[k]),
            .data_i      (s_data),
            .rnw_i       (s_rnw),
            .word_i      (s_word),
            .qual_o      (u_qual[k]),
            .hit_o       (u_hit[k])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic unused_hi_qual;
        assign unused_hi_qual = u_qual[2*p+1];

        bmb_pair #(.ADDR_W(ADDR_W)) u_pair (
            .mode_i        (rng_mode_e'(cfg_range_i[2*p +: 2])),
            .lo_qual_i     (u_qual[2*p]),
            .lo_hit_i      (u_hit[2*p]),
            .hi_hit_i      (u_hit[2*p+1]),
            .lo_bus_addr_i (u_bus_addr[2*p]),
            .min_addr_i    (cfg_addr_i[(2*p)*ADDR_W +: ADDR_W]),
            .max_addr_i    (cfg_addr_i[(2*p+1)*ADDR_W +: ADDR_W]),
            .match_o       (pair_match[2*p +: 2])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.match = pair_match;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign match_o = state_q.match;
endmodule

// File: rtl/bmb_chk.sv
module bmb_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bus0_valid_i,
    input logic       bus1_valid_i,
    input logic       bus0_rnw_i,
    input logic       bus1_rnw_i,
    input logic [3:0] cfg_en_i,
    input logic [3:0] cfg_bus_i,
    input logic [3:0] cfg_dir_en_i,
    input logic [3:0] cfg_dir_rd_i,
    input logic [3:0] cfg_range_i,
    input logic [3:0] match_o
);
    logic [3:0] sel_valid;
    logic [3:0] sel_rnw;

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            sel_valid[k] = cfg_bus_i[k] ? bus1_valid_i : bus0_valid_i;
            sel_rnw[k]   = cfg_bus_i[k] ? bus1_rnw_i : bus0_rnw_i;
        end
    end

    // R2
    no_strobe_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o != 4'b0) |-> $past(bus0_valid_i || bus1_valid_i));

    // R10
    upper_quiet_pair0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o[1] |-> $past(cfg_range_i[1:0] == 2'b00 || cfg_range_i[1:0] == 2'b11));

    // R10
    upper_quiet_pair1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o[3] |-> $past(cfg_range_i[3:2] == 2'b00 || cfg_range_i[3:2] == 2'b11));

    for (genvar k = 0; k < 4; k++) begin : g_unit_chk
        // R7
        disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            match_o[k] |-> $past(cfg_en_i[k]));

        // R2
        selected_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            match_o[k] |-> $past(sel_valid[k]));

        // R6
        direction_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (match_o[k] && $past(cfg_dir_en_i[k])) |-> $past(sel_rnw[k] == cfg_dir_rd_i[k]));
    end
endmodule

bind bus_match_bank bmb_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus0_valid_i (bus0_valid_i),
    .bus1_valid_i (bus1_valid_i),
    .bus0_rnw_i   (bus0_rnw_i),
    .bus1_rnw_i   (bus1_rnw_i),
    .cfg_en_i     (cfg_en_i),
    .cfg_bus_i    (cfg_bus_i),
    .cfg_dir_en_i (cfg_dir_en_i),
    .cfg_dir_rd_i (cfg_dir_rd_i),
    .cfg_range_i  (cfg_range_i),
    .match_o      (match_o)
);

// File: tb/bus_match_bank_tb.sv
module bus_match_bank_tb;
    localparam int AW = 23;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          b0_v, b0_rnw, b0_w, b1_v, b1_rnw, b1_w;
    logic [AW-1:0] b0_a, b1_a;
    logic [DW-1:0] b0_d, b1_d;
    logic [3:0]    en, bsel, dir_en, dir_rd, rng;
    logic [4*AW-1:0] caddr;
    logic [2*DW-1:0] cdata, cmask;
    logic [1:0]    sz_en, sz_w;
    logic [3:0]    match;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_match_bank u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .bus0_valid_i(b0_v), .bus0_addr_i(b0_a), .bus0_data_i(b0_d),
        .bus0_rnw_i(b0_rnw), .bus0_word_i(b0_w),
        .bus1_valid_i(b1_v), .bus1_addr_i(b1_a), .bus1_data_i(b1_d),
        .bus1_rnw_i(b1_rnw), .bus1_word_i(b1_w),
        .cfg_en_i(en), .cfg_bus_i(bsel), .cfg_dir_en_i(dir_en), .cfg_dir_rd_i(dir_rd),
        .cfg_addr_i(caddr), .cfg_data_i(cdata), .cfg_mask_i(cmask),
        .cfg_size_en_i(sz_en), .cfg_size_word_i(sz_w), .cfg_range_i(rng),
        .match_o(match)
    );

    function automatic logic [AW-1:0] ua(int k);
        return caddr[k*AW +: AW];
    endfunction

    function automatic logic [3:0] model();
        logic [3:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            logic v, rw, w, ok;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int p = k / 2;
            logic [1:0] m = rng[2*p +: 2];
            v  = bsel[k] ? b1_v : b0_v;
            a  = bsel[k] ? b1_a : b0_a;
            d  = bsel[k] ? b1_d : b0_d;
            rw = bsel[k] ? b1_rnw : b0_rnw;
            w  = bsel[k] ? b1_w : b0_w;
            ok = en[k] && v && (!dir_en[k] || rw == dir_rd[k]);
            if (m == 2'b01 || m == 2'b10) begin
                if (k % 2 == 1) ok = 0;
                else if (m == 2'b01) ok = ok && a >= ua(k) && a <= ua(k+1);
                else ok = ok && (a < ua(k) || a > ua(k+1));
            end else begin
                ok = ok && (a == ua(k));
                if (k % 2 == 0)
                    ok = ok && (((d ^ cdata[p*DW +: DW]) & cmask[p*DW +: DW]) == '0);
                else
                    ok = ok && (!sz_en[p] || w == sz_w[p]);
            end
            r[k] = ok;
        end
        return r;
    endfunction

    task automatic check(logic [3:0] exp, string tag);
        n_run++;
        if (match !== exp) begin
            n_fail++;
            $display("FAIL %s: match_o actual %b expected %b", tag, match, exp);
        end
    endtask

    task automatic step_check(logic [3:0] exp, string tag);
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic clear_all();
        b0_v = 0; b0_rnw = 0; b0_w = 0; b0_a = '0; b0_d = '0;
        b1_v = 0; b1_rnw = 0; b1_w = 0; b1_a = '0; b1_d = '0;
        en = '0; bsel = '0; dir_en = '0; dir_rd = '0; rng = '0;
        caddr = '0; cdata = '0; cmask = '0; sz_en = '0; sz_w = '0;
    endtask

    task automatic set_ua(int k, logic [AW-1:0] a);
        caddr[k*AW +: AW] = a;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(4'b0000, "R1 reset");
        step_check(4'b0000, "R1 idle");

        // R3 exact address on unit 0
        en = 4'b0001; set_ua(0, 23'h100);
        b0_v = 1; b0_a = 23'h100;
        step_check(4'b0001, "R3 equal");
        // R2 second consecutive strobe gives another pulse, then drop
        step_check(4'b0001, "R2 held strobe");
        b0_v = 0;
        step_check(4'b0000, "R2 no strobe");
        b0_v = 1; b0_a = 23'h101;
        step_check(4'b0000, "R3 unequal");

        // R4 masked data
        b0_a = 23'h100; cdata[DW-1:0] = 16'h1234; cmask[DW-1:0] = 16'hFF00;
        b0_d = 16'h12FF;
        step_check(4'b0001, "R4 masked bits ignored");
        b0_d = 16'h13FF;
        step_check(4'b0000, "R4 compared bit differs");

        // R5 size filter on unit 1
        clear_all(); en = 4'b0010; set_ua(1, 23'h200); sz_en = 2'b01; sz_w = 2'b01;
        b0_v = 1; b0_a = 23'h200; b0_w = 0;
        step_check(4'b0000, "R5 byte rejected");
        b0_w = 1;
        step_check(4'b0010, "R5 word accepted");

        // R6 direction on unit 2, coprocessor bus
        clear_all(); en = 4'b0100; bsel = 4'b0100; set_ua(2, 23'h300);
        dir_en = 4'b0100; dir_rd = 4'b0100;
        b1_v = 1; b1_a = 23'h300; b1_rnw = 0;
        step_check(4'b0000, "R6 write rejected");
        b1_rnw = 1;
        step_check(4'b0100, "R6 read accepted");
        // R2 wrong bus
        b1_v = 0; b0_v = 1; b0_a = 23'h300; b0_rnw = 1;
        step_check(4'b0000, "R2 other bus ignored");

        // R7 disabled unit 3
        clear_all(); set_ua(3, 23'h50); b0_v = 1; b0_a = 23'h50;
        step_check(4'b0000, "R7 disabled");
        en = 4'b1000;
        step_check(4'b1000, "R7 enabled");

        // R8 inside range on pair 0: min 0x400 max 0x410
        clear_all(); en = 4'b0011; set_ua(0, 23'h400); set_ua(1, 23'h410);
        cmask[DW-1:0] = 16'hFFFF; cdata[DW-1:0] = 16'h5555; rng = 4'b0001;
        b0_v = 1; b0_d = 16'h0000;
        b0_a = 23'h400; step_check(4'b0001, "R8 at min");
        b0_a = 23'h410; step_check(4'b0001, "R8 at max, R10 upper low");
        b0_a = 23'h3FF; step_check(4'b0000, "R8 below min");
        b0_a = 23'h411; step_check(4'b0000, "R8 above max");

        // R9 outside range
        rng = 4'b0010;
        b0_a = 23'h3FF; step_check(4'b0001, "R9 below min");
        b0_a = 23'h411; step_check(4'b0001, "R9 above max");
        b0_a = 23'h405; step_check(4'b0000, "R9 inside");
        b0_a = 23'h410; step_check(4'b0000, "R9 at max, R10 upper low");

        // R10 mode 11 behaves as exact
        rng = 4'b0011; cmask = '0;
        b0_a = 23'h410; step_check(4'b0010, "R10 mode 11 upper exact");
        b0_a = 23'h400; step_check(4'b0001, "R10 mode 11 lower exact");

        // Random phase, fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] exp;
            b0_v = $urandom % 4 != 0; b1_v = $urandom % 2 == 0;
            b0_a = 23'h1000 + $urandom % 6; b1_a = 23'h1000 + $urandom % 6;
            b0_d = 16'hA5A0 | 16'($urandom % 4); b1_d = 16'hA5A0 | 16'($urandom % 4);
            b0_rnw = $urandom % 2 == 0; b1_rnw = $urandom % 2 == 0;
            b0_w = $urandom % 2 == 0; b1_w = $urandom % 2 == 0;
            en = 4'($urandom | $urandom); bsel = 4'($urandom);
            dir_en = 4'($urandom); dir_rd = 4'($urandom); rng = 4'($urandom);
            for (int k = 0; k < 4; k++) set_ua(k, 23'h1000 + AW'($urandom % 6));
            cdata = {16'hA5A0 | 16'($urandom % 4), 16'hA5A0 | 16'($urandom % 4)};
            cmask = {16'($urandom), 16'($urandom)};
            sz_en = 2'($urandom); sz_w = 2'($urandom);
            exp = model();
            step_check(exp, "R2/R3/R4/R5/R6/R7/R8/R9/R10 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule